// File: doc/BRIEF.md
# Compare-Match Interval Timer with Square-Wave Output

This block is an 8-bit interval timer driven from a small write-port register bus. A free-running prescaler gives four internal count rates, and a synchronized external clock input gives a fifth. The counter advances once per selected count clock. When it equals a programmed reference value, the next count clock returns it to zero, sets a pending-interrupt flag and inverts an output latch. Successive matches therefore produce a square wave whose half-period is the reference plus one count clocks.

Software writes three registers: the mode register, the reference register and the control register. The mode register holds run/stop, clock select and a self-clearing restart command. The control register holds the output-enable and interrupt-enable flags. The count value is presented read-only on its own port. The output latch reaches the pin only while output enable is set, and the pending flag reaches the CPU interrupt line only while interrupt enable is set.

Top module: `interval_toggle_timer`

## Requirements
- R1: After synchronous reset, count_out, irq_flag, irq and tmr_out are 0, output enable and interrupt enable are 0, counting is stopped, and the reference register holds 255.
- R2: A write to address 0 with data bit 3 set clears the counter, the prescaler, the output latch and irq_flag at that edge. The bit is not stored, so a later address-0 write with bit 3 clear does not clear the count.
- R3: Address-0 data bit 2 is the run flag. While it is 0, count_out holds its value.
- R4: Address-0 bits 6:4 select the count clock. 100, 101, 110 and 111 give one count clock every 2, 8, 64 and 1024 system clocks, counted from a restart. 000 selects the external input. 001, 010 and 011 give no count clock.
- R5: On each count clock the count increases by 1. If the count already equals the reference, it goes to 0 instead, irq_flag is set and the output latch inverts, so the match period is reference + 1 count clocks.
- R6: With a reference of 0, the count stays 0 and the latch inverts on every count clock.
- R7: If the reference is written below the current count, counting continues upward with no match until the count wraps from 255 to 0.
- R8: ext_clk is synchronized through two flip-flops. Each rising edge gives exactly one count clock, however long the input stays high.
- R9: Address-2 data bit 0 is output enable. tmr_out equals the output latch ANDed with output enable, registered one clock later, so it is low whenever output enable is 0.
- R10: Address-2 data bit 1 is interrupt enable. irq equals irq_flag ANDed with interrupt enable, registered one clock later. irq_flag shows the pending flag directly.
- R11: Address 1 loads the reference. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 reference, 2 control |
| wr_data | input | 8 | Write data |
| count_out | output | 8 | Current count, read-only |
| irq_flag | output | 1 | Pending match flag |
| irq | output | 1 | Interrupt request to the CPU |
| tmr_out | output | 1 | Square-wave output pin |

## Verification
A corrupted prescaler or a wrong tap shows up as a wrong count_out after a known number of clocks following a restart, within one count period. A compare that fires one value early or late shows within a single match period as a wrong count, a wrong flag or a wrong latch phase. A gating fault on either enable shows one clock after the enable changes. Restart, run/stop and the external synchronizer each have directed sequences whose expected counts are worked out from the clock and edge counts alone.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int MODE_RUN_BIT   = 2;
  localparam int MODE_CLR_BIT   = 3;
  localparam int MODE_SEL_LSB   = 4;
  localparam int SEL_W          = 3;
  localparam int CTRL_OE_BIT    = 0;
  localparam int CTRL_IE_BIT    = 1;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_REF  = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int PRE_W = 10,
  parameter int NTAP  = 4,
  parameter logic [NTAP*4-1:0] TAP_POS = {4'd9, 4'd5, 4'd2, 4'd0}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic [NTAP-1:0] tick
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else            div_q <= div_q + 1'b1;
  end

  // each tap fires on the cycle its low bits are all ones
  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam int TP = int'(TAP_POS[i*4 +: 4]);
    assign tick[i] = &div_q[TP:0];
  end
endmodule

// File: rtl/itmr_ext_sync.sv
module itmr_ext_sync (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] ref_val,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             latch
);
  logic hit;
  assign hit = (count == ref_val);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      count <= '0;
      flag  <= 1'b0;
      latch <= 1'b0;
    end else if (run && tick) begin
      if (hit) begin
        count <= '0;
        flag  <= 1'b1;
        latch <= ~latch;
      end else begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/interval_toggle_timer.sv
module interval_toggle_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10,
  parameter int NTAP  = 4,
  parameter logic [NTAP*4-1:0] TAP_POS = {4'd9, 4'd5, 4'd2, 4'd0}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_out,
  output logic             irq_flag,
  output logic             irq,
  output logic             tmr_out
);
  localparam int IDX_W = $clog2(NTAP);

  logic             run_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] ref_q;
  logic             oe_q;
  logic             ie_q;
  logic             restart;
  logic [NTAP-1:0]  int_tick;
  logic             ext_rise;
  logic             cnt_tick;
  logic             flag;
  logic             latch;
  logic             tmr_q;
  logic             irq_q;

  assign restart = wr_en && (wr_addr == REG_MODE) && wr_data[MODE_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      sel_q <= '0;
      ref_q <= '1;
      oe_q  <= 1'b0;
      ie_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_MODE: begin
          run_q <= wr_data[MODE_RUN_BIT];
          sel_q <= wr_data[MODE_SEL_LSB +: SEL_W];
        end
        REG_REF:  ref_q <= wr_data;
        REG_CTRL: begin
          oe_q <= wr_data[CTRL_OE_BIT];
          ie_q <= wr_data[CTRL_IE_BIT];
        end
        default: ;
      endcase
    end
  end

  itmr_prescaler #(.PRE_W(PRE_W), .NTAP(NTAP), .TAP_POS(TAP_POS)) u_pre (
    .clk (clk),
    .rst (rst),
    .clr (restart),
    .tick(int_tick)
  );

  itmr_ext_sync u_sync (
    .clk   (clk),
    .rst   (rst),
    .ext_in(ext_clk),
    .rise  (ext_rise)
  );

  always_comb begin
    if (sel_q[SEL_W-1])       cnt_tick = int_tick[sel_q[IDX_W-1:0]];
    else if (sel_q == '0)     cnt_tick = ext_rise;
    else                      cnt_tick = 1'b0;
  end

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .run    (run_q),
    .tick   (cnt_tick),
    .ref_val(ref_q),
    .count  (count_out),
    .flag   (flag),
    .latch  (latch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      tmr_q <= latch & oe_q;
      irq_q <= flag & ie_q;
    end
  end

  assign irq_flag = flag;
  assign irq      = irq_q;
  assign tmr_out  = tmr_q;
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic [CNT_W-1:0] count_out,
  input logic             irq_flag,
  input logic             irq,
  input logic             tmr_out,
  input logic             oe,
  input logic             run
);
  logic clr_wr;
  assign clr_wr = wr_en && (wr_addr == 2'd0) && wr_data[3];

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count_out != $past(count_out)) |->
      (count_out == $past(count_out) + 1'b1 || count_out == '0));

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_flag) |-> (count_out == '0));

  // R2
  restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> (count_out == '0 && !irq_flag));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr_wr) |=> (count_out == $past(count_out)));

  // R9
  out_gate_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_out |-> $past(oe));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_flag));
endmodule

bind interval_toggle_timer itmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .count_out(count_out),
  .irq_flag (irq_flag),
  .irq      (irq),
  .tmr_out  (tmr_out),
  .oe       (oe_q),
  .run      (run_q)
);

// File: tb/interval_toggle_timer_test.sv
`timescale 1ns/1ps
module interval_toggle_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count_out;
  logic       irq_flag, irq, tmr_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  interval_toggle_timer uut (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count_out(count_out),
    .irq_flag(irq_flag), .irq(irq), .tmr_out(tmr_out)
  );

  // vector: {reference, clock select, clocks after restart}
  localparam int NV = 8;
  localparam logic [26:0] VEC [NV] = '{
    {8'd3,   3'b100, 16'd5},
    {8'd3,   3'b100, 16'd8},
    {8'd0,   3'b100, 16'd7},
    {8'd5,   3'b101, 16'd40},
    {8'd5,   3'b101, 16'd100},
    {8'd255, 3'b100, 16'd20},
    {8'd3,   3'b001, 16'd20},
    {8'd2,   3'b110, 16'd200}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; consumes exactly one rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic int period(input logic [2:0] sel);
    case (sel)
      3'b100: return 2;
      3'b101: return 8;
      3'b110: return 64;
      3'b111: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic int ticks(input int n, input int p);
    return (p == 0) ? 0 : n / p;
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", count_out, 0);
    check("R1 irq_flag", irq_flag, 0);
    check("R1 irq", irq, 0);
    check("R1 tmr_out", tmr_out, 0);
    repeat (5) @(negedge clk);
    check("R1 stopped", count_out, 0);

    // R1 reference resets to 255: run 600 clocks at period 2
    wr(2'd2, 8'h03);
    wr(2'd0, 8'b0100_1100);
    repeat (600) @(negedge clk);
    check("R1 ref255 count", count_out, 300 % 256);
    check("R1 ref255 flag", irq_flag, 1);

    // table walk: R4 R5 R6 R9 R10
    for (int v = 0; v < NV; v++) begin
      automatic logic [7:0] rv = VEC[v][26:19];
      automatic logic [2:0] sv = VEC[v][18:16];
      automatic int n = int'(VEC[v][15:0]);
      automatic int p = period(sv);
      automatic int t = ticks(n, p);
      automatic int tp = ticks(n - 1, p);
      wr(2'd1, rv);
      wr(2'd0, {1'b0, sv, 4'b1100});
      repeat (n) @(negedge clk);
      check($sformatf("R4/R5 count v%0d", v), count_out, t % (int'(rv) + 1));
      check($sformatf("R5 flag v%0d", v), irq_flag, (t > int'(rv)) ? 1 : 0);
      check($sformatf("R9 tmr_out v%0d", v), tmr_out, (tp / (int'(rv) + 1)) % 2);
      check($sformatf("R10 irq v%0d", v), irq, (tp > int'(rv)) ? 1 : 0);
    end

    // R7 reference lowered below current count
    wr(2'd1, 8'd255);
    wr(2'd0, 8'b0100_1100);
    repeat (20) @(negedge clk);
    check("R7 before", count_out, 10);
    wr(2'd1, 8'd3);
    repeat (10) @(negedge clk);
    check("R7 count past ref", count_out, 15);
    check("R7 no match", irq_flag, 0);

    // R3 stop without restart; R2 bit 3 not stored
    wr(2'd0, 8'b0100_0000);
    check("R2 no clear on plain mode write", count_out, 16);
    repeat (10) @(negedge clk);
    check("R3 hold", count_out, 16);

    // R11 address 3 ignored
    wr(2'd3, 8'hFF);
    repeat (3) @(negedge clk);
    check("R11 count", count_out, 16);
    check("R11 tmr_out", tmr_out, 0);
    check("R11 irq", irq, 0);

    // R9 R10 gating with enables off, then on
    wr(2'd2, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'b0111_1100);
    repeat (1030) @(negedge clk);
    check("R9 gated low", tmr_out, 0);
    check("R10 gated low", irq, 0);
    check("R10 flag visible", irq_flag, 1);
    wr(2'd2, 8'h03);
    @(negedge clk);
    check("R9 enabled", tmr_out, 1);
    check("R10 enabled", irq, 1);

    // R2 restart clears flag and latch
    wr(2'd0, 8'b0111_1100);
    check("R2 flag cleared", irq_flag, 0);
    check("R2 count cleared", count_out, 0);
    @(negedge clk);
    check("R2 latch cleared", tmr_out, 0);

    // R8 external edges, long high phases
    wr(2'd1, 8'd3);
    wr(2'd0, 8'b0000_1100);
    for (int k = 0; k < 5; k++) begin
      ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check("R8 ext count", count_out, 1);
    check("R8 ext flag", irq_flag, 1);
    check("R8 ext latch", tmr_out, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule